// File: doc/BRIEF.md
# NAND Operation Launcher

This block is the register front end of a NAND flash controller. Software programs a command byte, an address word, a chip-select choice and a buffer choice into 16-bit registers, then writes a one-hot trigger code that launches exactly one bus operation. The operation can be a command cycle, an address cycle, a page data input, a page data output, an ID read or a status read. The launcher hands a start pulse, a binary operation code and the stored command and address to a separate bus engine, which produces the NAND pin timing. When the engine returns its done pulse, the launcher raises a completion flag that software polls or receives as an interrupt.

A configuration register holds the interrupt mask (set means masked), the chip-enable bit, a pages-per-block code and a self-clearing soft reset. The soft reset returns every register to its reset value, holds for a fixed number of cycles and then drops by itself. A trigger write that arrives while an operation is still running is dropped, and so is a trigger write with more than one operation bit set.

Register map (3-bit word address): 0 = command, 1 = address, 2 = trigger/status, 3 = configuration, 4 = buffer select.

Top module: `nand_op_launcher`

## Requirements
- R1: After reset, the trigger register reads 0x0000, the configuration register reads 0x0010 (interrupt masked), the buffer register reads 0x0000, no start pulse is issued and irq is low.
- R2: Writing trigger bit k (k = 0 command, 1 address, 2 data input, 3 data output, 4 ID read, 5 status read) with the launcher idle gives a single-cycle eng_start in the cycle after the write, with eng_op = k and the command and address registers on eng_cmd and eng_addr. While running, trigger bits 5:0 read back the one-hot code of the running operation.
- R3: Trigger bit 15 is the completion flag; it is set in the cycle after eng_done is sampled high for a running operation, never in the same cycle as eng_done.
- R4: Writing the trigger register with bit 15 = 0 clears the flag; writing bit 15 = 1 leaves it unchanged.
- R5: irq is high exactly when the completion flag is 1 and configuration bit 4 (mask) is 0.
- R6: A trigger write that arrives while an operation is running issues no start pulse and leaves the running operation code unchanged.
- R7: A trigger write with more than one of bits 5:0 set issues no start pulse and leaves the launcher idle.
- R8: Buffer register bits 2:0 select the RAM buffer (buf_sel) and bits 6:5 select the chip; launching a data input or data output operation forces bits 2:0 to 0 while keeping bits 6:5, and other operations leave both fields unchanged.
- R9: Configuration bit 7 enables the chip: cs_onehot has bit s set (s = buffer register bits 6:5) when bit 7 is 1 and is all zero when bit 7 is 0; ce_o follows bit 7.
- R10: Configuration bits 10:9 give blk_pages = 32, 64, 128 or 256 for codes 0, 1, 2 and 3.
- R11: Writing configuration bit 6 = 1 starts a soft reset: bit 6 and srst_busy read 1 for exactly 4 cycles and then 0 by themselves, after which all registers hold their R1 reset values.
- R12: Register writes that arrive while the soft reset is in progress have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the register at reg_addr |
| eng_start | output | 1 | One-cycle launch pulse to the bus engine |
| eng_op | output | 3 | Binary code of the launched operation |
| eng_cmd | output | 16 | Stored command value |
| eng_addr | output | 16 | Stored address value |
| eng_done | input | 1 | Completion pulse from the bus engine |
| buf_sel | output | 3 | Selected RAM buffer |
| ce_o | output | 1 | Chip enable |
| cs_onehot | output | 4 | Active chip select, one-hot, gated by chip enable |
| blk_pages | output | 9 | Decoded pages per erase block |
| srst_busy | output | 1 | High while the soft reset runs |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions take for granted that eng_done is a single-cycle pulse that comes only after an eng_start and at most once per operation, as a bus engine would give; the flag and busy checks would not hold if done arrived for an operation never launched and were then counted. The bench keeps to this by driving eng_done from a stub engine that answers each start with one pulse a fixed three cycles later, and by launching new operations only after the previous completion, except in the scenario that deliberately writes the trigger while busy. Register writes are driven one at a time, away from the clock edge.

// File: rtl/nol_pkg.sv
package nol_pkg;

   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RSEL_CMD  = 3'd0,
      RSEL_ADDR = 3'd1,
      RSEL_TRIG = 3'd2,
      RSEL_CFG  = 3'd3,
      RSEL_BUF  = 3'd4
   } reg_sel_e;

   typedef enum logic [2:0] {
      OPC_CMD  = 3'd0,
      OPC_ADDR = 3'd1,
      OPC_DIN  = 3'd2,
      OPC_DOUT = 3'd3,
      OPC_ID   = 3'd4,
      OPC_STAT = 3'd5
   } op_code_e;

   localparam int CFG_MASK_BIT = 4;
   localparam int CFG_SRST_BIT = 6;
   localparam int CFG_CE_BIT   = 7;
   localparam int CFG_PPB_LSB  = 9;
   localparam int BUF_CS_LSB   = 5;
   localparam int TRIG_FLAG    = 15;

endpackage

// File: rtl/nol_soft_reset.sv
module nol_soft_reset #(
   parameter int RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic active
);
   localparam int CW = $clog2(RST_CYCLES + 1);

   generate
      if (RST_CYCLES < 1) begin : g_bad_len
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (req) begin
         cnt_q <= CW'(RST_CYCLES);
      end
   end

   assign active = (cnt_q != '0);

   // R11
   srst_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !active) |=> active);

endmodule

// File: rtl/nol_trig_ctrl.sv
module nol_trig_ctrl #(
   parameter int NUM_OPS = 6,
   localparam int OPW = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr_trig,
   input  logic [NUM_OPS-1:0] wr_ops,
   input  logic               wr_flag,
   input  logic               eng_done,
   output logic               busy,
   output logic               flag,
   output logic [NUM_OPS-1:0] cur_op,
   output logic               start,
   output logic [OPW-1:0]     op_idx,
   output logic               accept,
   output logic [OPW-1:0]     accept_idx
);

   generate
      if (NUM_OPS < 1 || NUM_OPS > 15) begin : g_bad_ops
         $error("NUM_OPS must be 1..15 to fit below the flag bit");
      end
   endgenerate

   // count of requested operation bits, built bit by bit
   logic [OPW:0] ones [NUM_OPS+1];
   logic [OPW-1:0] enc [NUM_OPS+1];
   assign ones[0] = '0;
   assign enc[0]  = '0;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_OPS; gi++) begin : g_scan
         assign ones[gi+1] = ones[gi] + (OPW+1)'(wr_ops[gi]);
         assign enc[gi+1]  = wr_ops[gi] ? OPW'(gi) : enc[gi];
      end
   endgenerate

   logic single;
   assign single     = (ones[NUM_OPS] == (OPW+1)'(1));
   assign accept     = wr_trig && !busy && single;
   assign accept_idx = enc[NUM_OPS];

   logic finish;
   assign finish = busy && eng_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cur_op <= '0;
         op_idx <= '0;
         start  <= 1'b0;
      end else if (clr) begin
         busy   <= 1'b0;
         cur_op <= '0;
         op_idx <= '0;
         start  <= 1'b0;
      end else begin
         start <= accept;
         if (accept) begin
            busy   <= 1'b1;
            cur_op <= wr_ops;
            op_idx <= accept_idx;
         end else if (finish) begin
            busy   <= 1'b0;
            cur_op <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (clr) begin
         flag <= 1'b0;
      end else if (finish) begin
         flag <= 1'b1;
      end else if (wr_trig && !wr_flag) begin
         flag <= 1'b0;
      end
   end

   // R2
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);

   // R3
   flag_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(eng_done));

   // R6
   start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (busy && !$past(busy)));

   // R7
   single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(cur_op) == 1));

endmodule

// File: rtl/nol_cfg_regs.sv
module nol_cfg_regs
   import nol_pkg::*;
#(
   parameter int DW         = 16,
   parameter int BUF_W      = 3,
   parameter int CS_W       = 2,
   parameter int PPB_W      = 2,
   parameter int PPB_BASE   = 32,
   parameter bit MASK_RESET = 1'b1,
   localparam int PG_W      = $clog2(PPB_BASE) + (1 << PPB_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic [REG_AW-1:0] waddr,
   input  logic [DW-1:0]    wdata,
   input  logic             page_launch,
   output logic [DW-1:0]    cmd_q,
   output logic [DW-1:0]    addr_q,
   output logic             mask_q,
   output logic             ce_q,
   output logic [PPB_W-1:0] ppb_q,
   output logic [BUF_W-1:0] buf_q,
   output logic [CS_W-1:0]  cs_q,
   output logic [PG_W-1:0]  pages
);

   generate
      if (BUF_W > BUF_CS_LSB) begin : g_bad_buf
         $error("buffer field overlaps the chip-select field");
      end
      if (BUF_CS_LSB + CS_W > DW) begin : g_bad_cs
         $error("chip-select field does not fit the register");
      end
      if (CFG_PPB_LSB + PPB_W > DW) begin : g_bad_ppb
         $error("pages-per-block field does not fit the register");
      end
      if ((PPB_BASE & (PPB_BASE - 1)) != 0) begin : g_bad_base
         $error("PPB_BASE must be a power of two");
      end
   endgenerate

   logic wr_cmd, wr_addr, wr_cfg, wr_buf;
   assign wr_cmd  = we && (waddr == RSEL_CMD);
   assign wr_addr = we && (waddr == RSEL_ADDR);
   assign wr_cfg  = we && (waddr == RSEL_CFG);
   assign wr_buf  = we && (waddr == RSEL_BUF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         addr_q <= '0;
      end else if (clr) begin
         cmd_q  <= '0;
         addr_q <= '0;
      end else begin
         if (wr_cmd)  cmd_q  <= wdata;
         if (wr_addr) addr_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= MASK_RESET;
         ce_q   <= 1'b0;
         ppb_q  <= '0;
      end else if (clr) begin
         mask_q <= MASK_RESET;
         ce_q   <= 1'b0;
         ppb_q  <= '0;
      end else if (wr_cfg) begin
         mask_q <= wdata[CFG_MASK_BIT];
         ce_q   <= wdata[CFG_CE_BIT];
         ppb_q  <= wdata[CFG_PPB_LSB +: PPB_W];
      end
   end

   // buffer field: page transfers always begin at buffer zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         cs_q  <= '0;
      end else if (clr) begin
         buf_q <= '0;
         cs_q  <= '0;
      end else begin
         if (wr_buf) begin
            buf_q <= wdata[BUF_W-1:0];
            cs_q  <= wdata[BUF_CS_LSB +: CS_W];
         end
         if (page_launch) begin
            buf_q <= '0;
         end
      end
   end

   assign pages = PG_W'(PPB_BASE) << ppb_q;

   // R8
   page_buf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (page_launch && !clr) |=> (buf_q == '0));

   // R11
   clr_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mask_q == MASK_RESET && cmd_q == '0 && buf_q == '0 && !ce_q));

endmodule

// File: rtl/nand_op_launcher.sv
module nand_op_launcher
   import nol_pkg::*;
#(
   parameter int DW         = 16,
   parameter int NUM_OPS    = 6,
   parameter int NUM_CS     = 4,
   parameter int BUF_W      = 3,
   parameter int PPB_W      = 2,
   parameter int PPB_BASE   = 32,
   parameter int RST_CYCLES = 4,
   localparam int OPW       = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1,
   localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int PG_W      = $clog2(PPB_BASE) + (1 << PPB_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              eng_start,
   output logic [OPW-1:0]    eng_op,
   output logic [DW-1:0]     eng_cmd,
   output logic [DW-1:0]     eng_addr,
   input  logic              eng_done,
   output logic [BUF_W-1:0]  buf_sel,
   output logic              ce_o,
   output logic [NUM_CS-1:0] cs_onehot,
   output logic [PG_W-1:0]   blk_pages,
   output logic              srst_busy,
   output logic              irq
);

   generate
      if (DW != 16) begin : g_bad_dw
         $error("register width fixed at 16 bits");
      end
      if (NUM_OPS <= OPC_DOUT) begin : g_bad_ops
         $error("operation set must include data input and output");
      end
   endgenerate

   logic we_eff;
   logic srst_req;
   logic busy, flag, accept;
   logic [NUM_OPS-1:0] cur_op;
   logic [OPW-1:0] accept_idx;
   logic page_launch;
   logic mask_q, ce_q;
   logic [PPB_W-1:0] ppb_q;
   logic [CS_W-1:0] cs_q;

   // writes are dropped while the soft reset runs
   assign we_eff   = reg_we && !srst_busy;
   assign srst_req = we_eff && (reg_addr == RSEL_CFG) && reg_wdata[CFG_SRST_BIT];

   nol_soft_reset #(.RST_CYCLES(RST_CYCLES)) u_srst (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (srst_req),
      .active (srst_busy)
   );

   logic wr_trig;
   assign wr_trig = we_eff && (reg_addr == RSEL_TRIG);

   nol_trig_ctrl #(.NUM_OPS(NUM_OPS)) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (srst_busy),
      .wr_trig    (wr_trig),
      .wr_ops     (reg_wdata[NUM_OPS-1:0]),
      .wr_flag    (reg_wdata[TRIG_FLAG]),
      .eng_done   (eng_done),
      .busy       (busy),
      .flag       (flag),
      .cur_op     (cur_op),
      .start      (eng_start),
      .op_idx     (eng_op),
      .accept     (accept),
      .accept_idx (accept_idx)
   );

   assign page_launch = accept && ((accept_idx == OPW'(OPC_DIN)) ||
                                   (accept_idx == OPW'(OPC_DOUT)));

   nol_cfg_regs #(
      .DW       (DW),
      .BUF_W    (BUF_W),
      .CS_W     (CS_W),
      .PPB_W    (PPB_W),
      .PPB_BASE (PPB_BASE)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (srst_busy),
      .we          (we_eff),
      .waddr       (reg_addr),
      .wdata       (reg_wdata),
      .page_launch (page_launch),
      .cmd_q       (eng_cmd),
      .addr_q      (eng_addr),
      .mask_q      (mask_q),
      .ce_q        (ce_q),
      .ppb_q       (ppb_q),
      .buf_q       (buf_sel),
      .cs_q        (cs_q),
      .pages       (blk_pages)
   );

   assign ce_o = ce_q;

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CS; gc++) begin : g_cs
         assign cs_onehot[gc] = ce_q && (cs_q == CS_W'(gc));
      end
   endgenerate

   assign irq = flag && !mask_q;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RSEL_CMD:  reg_rdata = eng_cmd;
         RSEL_ADDR: reg_rdata = eng_addr;
         RSEL_TRIG: begin
            reg_rdata[NUM_OPS-1:0] = cur_op;
            reg_rdata[TRIG_FLAG]   = flag;
         end
         RSEL_CFG: begin
            reg_rdata[CFG_MASK_BIT]            = mask_q;
            reg_rdata[CFG_SRST_BIT]            = srst_busy;
            reg_rdata[CFG_CE_BIT]              = ce_q;
            reg_rdata[CFG_PPB_LSB +: PPB_W]    = ppb_q;
         end
         RSEL_BUF: begin
            reg_rdata[BUF_W-1:0]               = buf_sel;
            reg_rdata[BUF_CS_LSB +: CS_W]      = cs_q;
         end
         default: reg_rdata = '0;
      endcase
   end

   // R11
   no_start_in_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst_busy |=> !eng_start);

   // R9
   cs_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_onehot));

   // R5
   irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(eng_done) || $fell(mask_q)));

endmodule

// File: tb/nand_op_launcher_bench.sv
module nand_op_launcher_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        eng_start;
   logic [2:0]  eng_op;
   logic [15:0] eng_cmd, eng_addr;
   logic        eng_done = 1'b0;
   logic [2:0]  buf_sel;
   logic        ce_o;
   logic [3:0]  cs_onehot;
   logic [8:0]  blk_pages;
   logic        srst_busy;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   int starts = 0;
   int eng_cnt = 0;
   logic [15:0] seen_cmd = '0;
   logic [15:0] seen_addr = '0;

   localparam logic [2:0] A_CMD = 3'd0, A_ADDR = 3'd1, A_TRIG = 3'd2,
                          A_CFG = 3'd3, A_BUF = 3'd4;

   always #10 clk = ~clk;

   nand_op_launcher u_nand_op_launcher (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
      .eng_op(eng_op), .eng_cmd(eng_cmd), .eng_addr(eng_addr),
      .eng_done(eng_done), .buf_sel(buf_sel), .ce_o(ce_o),
      .cs_onehot(cs_onehot), .blk_pages(blk_pages), .srst_busy(srst_busy),
      .irq(irq)
   );

   // stub bus engine: one done pulse three cycles after each start
   always @(posedge clk) begin
      if (eng_start) begin
         eng_cnt   <= 3;
         eng_done  <= 1'b0;
         starts    <= starts + 1;
         seen_cmd  <= eng_cmd;
         seen_addr <= eng_addr;
      end else if (eng_cnt == 1) begin
         eng_done <= 1'b1;
         eng_cnt  <= 0;
      end else begin
         eng_done <= 1'b0;
         if (eng_cnt != 0) eng_cnt <= eng_cnt - 1;
      end
   end

   initial begin
      #4_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // wait for the engine's done pulse, then check flag timing
   task automatic wait_done(input string req);
      logic [15:0] v;
      for (int i = 0; i < 20 && !eng_done; i++) @(negedge clk);
      rd(A_TRIG, v);
      chk({req, " flag clear while done high"}, {31'b0, v[15]}, 32'd0);
      @(negedge clk);
      rd(A_TRIG, v);
      chk({req, " flag set after done"}, {16'b0, v}, 32'h8000);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(A_TRIG, v); chk("R1 trig", v, 16'h0000);
      rd(A_CFG, v);  chk("R1 cfg", v, 16'h0010);
      rd(A_BUF, v);  chk("R1 buf", v, 16'h0000);
      chk("R1 irq", irq, 0);
      chk("R1 start", eng_start, 0);
   endtask

   task automatic t_ops;
      logic [15:0] v;
      for (int k = 0; k < 6; k++) begin
         wr(A_CMD, 16'h0070 + 16'(k));
         wr(A_ADDR, 16'h1200 + 16'(k));
         wr(A_TRIG, 16'(1 << k));
         chk("R2 start pulse", eng_start, 1);
         chk("R2 op code", eng_op, k);
         rd(A_TRIG, v);
         chk("R2 running code", v, 16'(1 << k));
         @(negedge clk);
         chk("R2 single pulse", eng_start, 0);
         chk("R2 cmd to engine", seen_cmd, 16'h0070 + 16'(k));
         chk("R2 addr to engine", seen_addr, 16'h1200 + 16'(k));
         wait_done("R3");
         wr(A_TRIG, 16'h0000);
      end
   endtask

   task automatic t_flag_irq;
      logic [15:0] v;
      wr(A_CFG, 16'h0000);
      wr(A_TRIG, 16'h0010);
      wait_done("R3");
      chk("R5 irq unmasked", irq, 1);
      wr(A_CFG, 16'h0010);
      chk("R5 irq masked", irq, 0);
      wr(A_CFG, 16'h0000);
      wr(A_TRIG, 16'h8000);
      rd(A_TRIG, v);
      chk("R4 write one keeps flag", v, 16'h8000);
      wr(A_TRIG, 16'h0000);
      rd(A_TRIG, v);
      chk("R4 write zero clears flag", v, 16'h0000);
      chk("R5 irq after clear", irq, 0);
   endtask

   task automatic t_busy_ignore;
      logic [15:0] v;
      int s0;
      s0 = starts;
      wr(A_TRIG, 16'h0001);
      wr(A_TRIG, 16'h0002);
      @(negedge clk);
      chk("R6 no second start", starts - s0, 1);
      rd(A_TRIG, v);
      chk("R6 op unchanged", {16'b0, v} & 32'h3F, 32'h01);
      wait_done("R6");
      wr(A_TRIG, 16'h0000);
      @(negedge clk);
      chk("R6 still one start", starts - s0, 1);
   endtask

   task automatic t_multi_ignore;
      logic [15:0] v;
      int s0;
      s0 = starts;
      wr(A_TRIG, 16'h0003);
      @(negedge clk);
      @(negedge clk);
      chk("R7 no start", starts - s0, 0);
      rd(A_TRIG, v);
      chk("R7 idle", v, 16'h0000);
   endtask

   task automatic t_buf;
      logic [15:0] v;
      wr(A_BUF, 16'h0025);
      chk("R8 buf_sel", buf_sel, 5);
      wr(A_TRIG, 16'h0001);
      wait_done("R8");
      rd(A_BUF, v);
      chk("R8 command keeps buffer", v, 16'h0025);
      wr(A_TRIG, 16'h0004);
      rd(A_BUF, v);
      chk("R8 data input resets buffer", v, 16'h0020);
      wait_done("R8");
      wr(A_BUF, 16'h0046);
      wr(A_TRIG, 16'h0008);
      rd(A_BUF, v);
      chk("R8 data output resets buffer", v, 16'h0040);
      wait_done("R8");
      wr(A_TRIG, 16'h0000);
   endtask

   task automatic t_cs;
      wr(A_BUF, 16'h0020);
      wr(A_CFG, 16'h0080);
      chk("R9 cs one-hot", cs_onehot, 4'b0010);
      chk("R9 ce", ce_o, 1);
      wr(A_BUF, 16'h0060);
      chk("R9 cs three", cs_onehot, 4'b1000);
      wr(A_CFG, 16'h0000);
      chk("R9 cs gated", cs_onehot, 4'b0000);
      chk("R9 ce off", ce_o, 0);
   endtask

   task automatic t_ppb;
      for (int c = 0; c < 4; c++) begin
         wr(A_CFG, 16'(c << 9));
         chk("R10 pages per block", blk_pages, 32 << c);
      end
   endtask

   task automatic t_srst;
      logic [15:0] v;
      wr(A_CMD, 16'h00AB);
      wr(A_BUF, 16'h0023);
      wr(A_CFG, 16'h0280);
      wr(A_TRIG, 16'h0002);
      wait_done("R11");
      wr(A_CFG, 16'h0040);
      rd(A_CFG, v);
      chk("R11 bit6 cycle1", v[6], 1);
      chk("R11 busy cycle1", srst_busy, 1);
      wr(A_CMD, 16'hBEEF);
      chk("R11 busy cycle3", srst_busy, 1);
      @(negedge clk);
      chk("R11 busy cycle4", srst_busy, 1);
      @(negedge clk);
      chk("R11 self clear", srst_busy, 0);
      rd(A_CFG, v);  chk("R11 cfg default", v, 16'h0010);
      rd(A_TRIG, v); chk("R11 flag cleared", v, 16'h0000);
      rd(A_BUF, v);  chk("R11 buf cleared", v, 16'h0000);
      rd(A_CMD, v);  chk("R12 write during reset dropped", v, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_ops;
      t_flag_irq;
      t_busy_ignore;
      t_multi_ignore;
      t_buf;
      t_cs;
      t_ppb;
      t_srst;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule